// File: doc/BRIEF.md
# Nonvolatile Array Write-Protection Guard

This block sits between a memory front end and a 4 KB nonvolatile array and decides, request by request, whether a write may proceed. It holds a three-bit protection configuration: a two-bit range code that fences off the top quarter, the top half or the whole of the array, and a lock-enable bit. When the lock-enable bit is set and the external write-protect pin is high, the configuration freezes. This includes the lock-enable bit itself, so only pulling the pin low releases it.

A request carries a valid strobe, a type flag selecting an array write or a configuration write, a 12-bit array address and three bits of new configuration data. Exactly one cycle later the block pulses either a grant or a reject. Granted configuration writes take effect in the same cycle that the grant is shown. The write-protect pin passes through a two-stage synchroniser before it is used. The reset value of the configuration is a parameter that stands in for the stored nonvolatile contents.

Top module: `prot_ctrl`

## Requirements
- R1: After reset, `status` equals the `INIT_CFG` parameter (default 3'b000) and both `grant` and `reject` are 0.
- R2: A request sampled with `req_valid`=1 at a rising edge yields exactly one of `grant`/`reject` high for the following cycle. With `req_valid`=0, neither is high in the following cycle.
- R3: With range code `status[1:0]`=00, every array write (`req_is_reg`=0) is granted.
- R4: With range code 01, array writes to addresses C00h–FFFh are rejected and addresses 000h–BFFh are granted.
- R5: With range code 10, array writes to addresses 800h–FFFh are rejected and addresses 000h–7FFh are granted.
- R6: With range code 11, every array write is rejected.
- R7: The array decision depends only on the range code and the address. It is the same for every combination of pin level and lock-enable bit.
- R8: A configuration write (`req_is_reg`=1) is granted when the synchronised pin is low or `status[2]` (lock enable) is 0. On the grant cycle, `status` shows `req_data`, laid out as bit 2 lock enable and bits 1:0 range code.
- R9: When the synchronised pin is high and `status[2]`=1, a configuration write is rejected and `status` keeps its value. This includes an attempt to clear bit 2.
- R10: A level change on `wp_pin` takes effect for requests sampled at the third rising edge after the change and later. Requests at the first and second edges still see the old level.
- R11: Array writes and idle cycles never change `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin | input | 1 | Asynchronous write-protect pin level |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_is_reg | input | 1 | 1 = configuration write, 0 = array write |
| req_addr | input | 12 | Array address of an array write |
| req_data | input | 3 | New configuration {lock enable, range code} |
| grant | output | 1 | Write allowed, one cycle after the request |
| reject | output | 1 | Write refused, one cycle after the request |
| status | output | 3 | Current configuration {lock enable, range code} |

## Verification
The hardest situation to reach is a request that lands while the pin change is still inside the synchroniser. In that window the raw pin and the level used for the decision disagree. The stimulus reaches it by locking the configuration and then dropping the pin on the same half-cycle as the first of three back-to-back unlock attempts. The first two attempts must be refused and the third accepted. The reverse order, setting the lock bit and then raising the pin under back-to-back writes, checks the opposite direction. Every range code is also swept against all four pin and lock combinations, using the two ends of each 64-byte address slice.

// File: rtl/prot_pkg.sv
package prot_pkg;
    typedef struct packed {
        logic       lock_en;
        logic [1:0] range_code;
    } prot_cfg_t;

    typedef struct packed {
        prot_cfg_t cfg;
        logic      grant;
        logic      reject;
    } prot_state_t;
endpackage

// File: rtl/prot_pin_sync.sv
module prot_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/prot_range_check.sv
module prot_range_check #(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        range_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (range_code)
            2'b00:   hit = 1'b0;
            2'b01:   hit = addr[TOP] & addr[TOP-1];
            2'b10:   hit = addr[TOP];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
    import prot_pkg::*;
#(
    parameter int         ADDR_W      = 12,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] INIT_CFG    = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              req_valid,
    input  logic              req_is_reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_data,
    output logic              grant,
    output logic              reject,
    output logic [2:0]        status
);
    prot_state_t st_d, st_q;
    logic        wp_s;
    logic        range_hit;
    logic        cfg_locked;

    prot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (wp_pin),
        .pin_sync  (wp_s)
    );

    prot_range_check #(.ADDR_W(ADDR_W)) u_range (
        .range_code (st_q.cfg.range_code),
        .addr       (req_addr),
        .hit        (range_hit)
    );

    assign cfg_locked = wp_s & st_q.cfg.lock_en;

    always_comb begin
        st_d        = st_q;
        st_d.grant  = 1'b0;
        st_d.reject = 1'b0;
        if (req_valid) begin
            if (req_is_reg) begin
                if (cfg_locked) begin
                    st_d.reject = 1'b1;
                end else begin
                    st_d.grant = 1'b1;
                    st_d.cfg   = prot_cfg_t'(req_data);
                end
            end else if (range_hit) begin
                st_d.reject = 1'b1;
            end else begin
                st_d.grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg    <= prot_cfg_t'(INIT_CFG);
            st_q.grant  <= 1'b0;
            st_q.reject <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant  = st_q.grant;
    assign reject = st_q.reject;
    assign status = st_q.cfg;
endmodule

// File: rtl/prot_ctrl_chk.sv
module prot_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_is_reg,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_data,
    input logic              grant,
    input logic              reject,
    input logic [2:0]        status,
    input logic              wp_s
);
    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || reject));

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !reject));

    a_r6_full_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_reg && status[1:0] == 2'b11) |=> reject);

    a_r5_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_reg && status[1:0] == 2'b10 && req_addr[ADDR_W-1]) |=> reject);

    a_r3_open_array: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_reg && status[1:0] == 2'b00) |=> grant);

    a_r8_unlocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_reg && !(wp_s && status[2])) |=> (grant && status == $past(req_data)));

    a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_reg && wp_s && status[2]) |=> (reject && $stable(status)));

    a_r11_array_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_is_reg) |=> $stable(status));
endmodule

bind prot_ctrl prot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_reg (req_is_reg),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .grant      (grant),
    .reject     (reject),
    .status     (status),
    .wp_s       (wp_s)
);

// File: tb/prot_ctrl_tb.sv
`timescale 1ns/1ps
module prot_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_pin = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_reg = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_data = '0;
    logic        grant, reject;
    logic [2:0]  status;

    int checks = 0;
    int fails = 0;
    logic [2:0] model_cfg = 3'b000;

    always #2 clk = ~clk;

    prot_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .req_valid(req_valid),
        .req_is_reg(req_is_reg), .req_addr(req_addr), .req_data(req_data),
        .grant(grant), .reject(reject), .status(status)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit in_fence(input logic [1:0] code, input int a);
        case (code)
            2'd0: return 1'b0;
            2'd1: return a >= 3072;
            2'd2: return a >= 2048;
            default: return 1'b1;
        endcase
    endfunction

    // Drive at negedge, decision registered at posedge, sample at next negedge.
    task automatic do_req(input bit is_reg, input int a, input logic [2:0] d,
                          input bit wp_seen, input string tag);
        bit exp_g;
        req_valid = 1'b1; req_is_reg = is_reg; req_addr = a[11:0]; req_data = d;
        if (is_reg) exp_g = !(wp_seen && model_cfg[2]);
        else        exp_g = !in_fence(model_cfg[1:0], a);
        if (is_reg && exp_g) model_cfg = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(grant == exp_g && reject == !exp_g, tag, {grant, reject}, {exp_g, !exp_g});
        check(status == model_cfg, is_reg ? tag : "R11", status, model_cfg);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(!grant && !reject, "R2 idle", {grant, reject}, 0);
    endtask

    task automatic settle_pin(input bit lvl);
        wp_pin = lvl;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] code, input bit en, input bit wp);
        settle_pin(1'b0);
        do_req(1'b1, 0, {en, code}, 1'b0, "R8");
        settle_pin(wp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        string rtag;
        repeat (3) @(negedge clk);
        check(status == 3'b000 && !grant && !reject, "R1", {status, grant, reject}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check();

        // R3..R7: every code against every pin/lock combination.
        for (int code = 0; code < 4; code++) begin
            for (int combo = 0; combo < 4; combo++) begin
                set_cfg(code[1:0], combo[0], combo[1]);
                case (code)
                    0: rtag = "R3/R7";
                    1: rtag = "R4/R7";
                    2: rtag = "R5/R7";
                    default: rtag = "R6/R7";
                endcase
                for (int a = 0; a < 4096; a += 64) begin
                    do_req(1'b0, a, 3'b000, combo[1], rtag);
                    do_req(1'b0, a + 63, 3'b000, combo[1], rtag);
                end
                idle_check();
            end
        end

        // R9: locked config refuses every new value, including clearing the lock bit.
        set_cfg(2'b01, 1'b1, 1'b1);
        for (int d = 0; d < 8; d++) do_req(1'b1, 0, d[2:0], 1'b1, "R9");
        do_req(1'b0, 3071, 3'b000, 1'b1, "R4");
        do_req(1'b0, 3072, 3'b000, 1'b1, "R4");

        // R10: drop the pin and retry at once; third attempt onward sees the low level.
        wp_pin = 1'b0;
        do_req(1'b1, 0, 3'b000, 1'b1, "R10 edge1");
        do_req(1'b1, 0, 3'b000, 1'b1, "R10 edge2");
        do_req(1'b1, 0, 3'b000, 1'b0, "R10 edge3");
        idle_check();

        // R8: lock bit can be set while pin is high, then blocks further changes.
        set_cfg(2'b10, 1'b0, 1'b1);
        do_req(1'b1, 0, 3'b110, 1'b1, "R8 set lock");
        do_req(1'b1, 0, 3'b000, 1'b1, "R9 after lock");

        // R10 reverse: unlocked with pin low, raise pin under back-to-back writes.
        set_cfg(2'b00, 1'b1, 1'b0);
        wp_pin = 1'b1;
        do_req(1'b1, 0, 3'b101, 1'b0, "R10 rise edge1");
        do_req(1'b1, 0, 3'b110, 1'b0, "R10 rise edge2");
        do_req(1'b1, 0, 3'b000, 1'b1, "R10 rise edge3");
        idle_check();
        repeat (2) idle_check();
        check(status == model_cfg, "R11 idle", status, model_cfg);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule